// File: doc/BRIEF.md
# Interrupt Priority Arbitration Unit

This unit sits between an interrupt distributor's state storage and the interrupt request lines of up to eight processor cores. For every core it looks at all interrupt IDs that are both enabled and pending in that core's view and picks the most urgent one. A smaller priority number is more urgent. When two candidates have the same priority, the smaller ID wins.

Two thresholds then act on the winner. The core's priority mask decides whether the winner is reported as the highest-pending ID at all. The core's running priority, which is the priority of the interrupt it is servicing now, decides whether the request line is raised. IDs 0 to 31 are private, and each core has its own priority byte for them. IDs 32 and above use one priority byte that all cores share. Both outputs are registered, so they follow the inputs with exactly one clock of latency.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among the IDs that are enabled and pending for a core, the one with the smallest 8-bit priority value is selected.
- R2: When several candidates share the smallest priority value, the smallest ID is selected.
- R3: An ID that is pending but not enabled, or enabled but not pending, is never reported. With no candidate, the reported ID is 1023 and the request line is low.
- R4: While the global enable `dist_en` is low, or the core's `cpu_if_en` bit is low, that core reports 1023 and its request line is low.
- R5: The winner is reported only when its priority is less than or equal to the core's mask. Equality passes. Otherwise the core reports 1023.
- R6: The request line is high only when the winner passes the mask and its priority is strictly smaller than the core's 9-bit running priority. Equality keeps the line low. A running priority of 0x100 means idle, and any winner that passes the mask then raises the line.
- R7: For IDs 0 to 31, core c uses `prio_private[(c*32+i)*8 +: 8]`. For an ID i of 32 or more, every core uses `prio_shared[(i-32)*8 +: 8]`. Another core's private priorities have no effect.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high, every core reports 1023 with its request line low.
- R9: Each core arbitrates only over its own slice of the enable and pending vectors, bits `[c*NUM_IRQ +: NUM_IRQ]`. The reported ID is `pend_id[c*10 +: 10]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Global forwarding enable |
| cpu_if_en | input | NUM_CPU | Per-core interface enable |
| irq_en | input | NUM_CPU*NUM_IRQ | Per-core view of the enable bits |
| irq_pend | input | NUM_CPU*NUM_IRQ | Per-core view of the pending bits |
| prio_private | input | NUM_CPU*32*8 | Per-core priorities of IDs 0 to 31 |
| prio_shared | input | max(NUM_IRQ-32,1)*8 | Shared priorities of IDs 32 and above |
| prio_mask | input | NUM_CPU*8 | Per-core reporting threshold |
| run_prio | input | NUM_CPU*9 | Per-core running priority, where 0x100 means idle |
| pend_id | output | NUM_CPU*10 | Per-core highest-pending ID, 1023 when there is none |
| irq_out | output | NUM_CPU | Per-core interrupt request |

## Verification
The bench compares every core's outputs with a behavioural model on every clock. Directed stimulus comes first:
- Single candidates, and candidates that are pending but not enabled, show the eligibility filter at work.
- Pairs and triples with equal priorities separate a strict comparison from a non-strict one, and the lowest-ID rule from a highest-ID rule.
- Mask and running-priority values set exactly at, one below and one above the winner's priority expose off-by-one errors in either threshold.
- Setting the two cores' private priorities for the same ID to opposite values shows that the banking is correct.

A long run of pseudo-random enables, pending bits and priorities drawn from a small value set then produces many ties and threshold collisions.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = 9;
  localparam int ID_W   = 10;
  localparam int PRIV_N = 32;
  localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
  localparam logic [RUN_W-1:0] IDLE_PRIO   = 9'h100;
endpackage

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// Combinational minimum search over one core's candidates.
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int SHARED_N = 32
) (
  input  logic [NUM_IRQ-1:0]         en,
  input  logic [NUM_IRQ-1:0]         pend,
  input  logic [PRIV_N*PRIO_W-1:0]   prio_priv,
  input  logic [SHARED_N*PRIO_W-1:0] prio_shr,
  output logic [RUN_W-1:0]           best_prio,
  output logic [ID_W-1:0]            best_id
);
  // Effective priority per ID; ineligible IDs get the idle sentinel.
  logic [RUN_W-1:0] eff [NUM_IRQ];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_eff
      if (gi < PRIV_N) begin : g_priv
        assign eff[gi] = (en[gi] && pend[gi]) ?
                         {1'b0, prio_priv[gi*PRIO_W +: PRIO_W]} : IDLE_PRIO;
      end else begin : g_shr
        assign eff[gi] = (en[gi] && pend[gi]) ?
                         {1'b0, prio_shr[(gi-PRIV_N)*PRIO_W +: PRIO_W]} : IDLE_PRIO;
      end
    end
  endgenerate

  // Ascending scan with strict compare: lowest ID wins a tie.
  always_comb begin
    best_prio = IDLE_PRIO;
    best_id   = SPURIOUS_ID;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eff[i] < best_prio) begin
        best_prio = eff[i];
        best_id   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_cpu_gate.sv
`timescale 1ns/1ps
// Applies enables and both thresholds, then registers the result.
module irq_cpu_gate
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              glob_en,
  input  logic              if_en,
  input  logic [RUN_W-1:0]  best_prio,
  input  logic [ID_W-1:0]   best_id,
  input  logic [PRIO_W-1:0] mask,
  input  logic [RUN_W-1:0]  running,
  output logic [ID_W-1:0]   id_q,
  output logic              irq_q
);
  logic pass_mask;
  logic open;

  assign open      = glob_en && if_en;
  assign pass_mask = best_prio <= {1'b0, mask};

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= SPURIOUS_ID;
      irq_q <= 1'b0;
    end else if (!open) begin
      id_q  <= SPURIOUS_ID;
      irq_q <= 1'b0;
    end else begin
      id_q  <= pass_mask ? best_id : SPURIOUS_ID;
      irq_q <= pass_mask && (best_prio < running);
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_CPU  = 2,
  parameter int SHARED_N = (NUM_IRQ > PRIV_N) ? NUM_IRQ - PRIV_N : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dist_en,
  input  logic [NUM_CPU-1:0]           cpu_if_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0]   irq_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0]   irq_pend,
  input  logic [NUM_CPU*PRIV_N*PRIO_W-1:0] prio_private,
  input  logic [SHARED_N*PRIO_W-1:0]   prio_shared,
  input  logic [NUM_CPU*PRIO_W-1:0]    prio_mask,
  input  logic [NUM_CPU*RUN_W-1:0]     run_prio,
  output logic [NUM_CPU*ID_W-1:0]      pend_id,
  output logic [NUM_CPU-1:0]           irq_out
);
  localparam int PRIV_BITS = PRIV_N * PRIO_W;

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
      logic [RUN_W-1:0] best_prio;
      logic [ID_W-1:0]  best_id;

      irq_prio_pick #(
        .NUM_IRQ (NUM_IRQ),
        .SHARED_N(SHARED_N)
      ) u_pick (
        .en       (irq_en[gc*NUM_IRQ +: NUM_IRQ]),
        .pend     (irq_pend[gc*NUM_IRQ +: NUM_IRQ]),
        .prio_priv(prio_private[gc*PRIV_BITS +: PRIV_BITS]),
        .prio_shr (prio_shared),
        .best_prio(best_prio),
        .best_id  (best_id)
      );

      irq_cpu_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .glob_en  (dist_en),
        .if_en    (cpu_if_en[gc]),
        .best_prio(best_prio),
        .best_id  (best_id),
        .mask     (prio_mask[gc*PRIO_W +: PRIO_W]),
        .running  (run_prio[gc*RUN_W +: RUN_W]),
        .id_q     (pend_id[gc*ID_W +: ID_W]),
        .irq_q    (irq_out[gc])
      );
    end
  endgenerate
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
`timescale 1ns/1ps
module irq_prio_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_CPU  = 2,
  parameter int SHARED_N = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         dist_en,
  input logic [NUM_CPU-1:0]           cpu_if_en,
  input logic [NUM_CPU*NUM_IRQ-1:0]   irq_en,
  input logic [NUM_CPU*NUM_IRQ-1:0]   irq_pend,
  input logic [NUM_CPU*PRIV_N*PRIO_W-1:0] prio_private,
  input logic [SHARED_N*PRIO_W-1:0]   prio_shared,
  input logic [NUM_CPU*PRIO_W-1:0]    prio_mask,
  input logic [NUM_CPU*RUN_W-1:0]     run_prio,
  input logic [NUM_CPU*ID_W-1:0]      pend_id,
  input logic [NUM_CPU-1:0]           irq_out
);
  // Inputs as seen at the previous edge, to match the registered outputs.
  logic [NUM_CPU*NUM_IRQ-1:0]       en_q, pd_q;
  logic [NUM_CPU*PRIV_N*PRIO_W-1:0] pp_q;
  logic [SHARED_N*PRIO_W-1:0]       ps_q;
  logic [NUM_CPU*PRIO_W-1:0]        mk_q;
  logic [NUM_CPU*RUN_W-1:0]         rn_q;

  always_ff @(posedge clk) begin
    en_q <= irq_en;
    pd_q <= irq_pend;
    pp_q <= prio_private;
    ps_q <= prio_shared;
    mk_q <= prio_mask;
    rn_q <= run_prio;
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CPU; gc++) begin : g_chk
      logic [ID_W-1:0]  id_c;
      logic [RUN_W-1:0] rep_p;
      logic             elig;
      int               idx;

      assign id_c = pend_id[gc*ID_W +: ID_W];
      assign idx  = int'(id_c);

      always_comb begin
        rep_p = IDLE_PRIO;
        elig  = 1'b0;
        if (idx < NUM_IRQ) begin
          elig = en_q[gc*NUM_IRQ + idx] && pd_q[gc*NUM_IRQ + idx];
          if (idx < PRIV_N)
            rep_p = {1'b0, pp_q[(gc*PRIV_N + idx)*PRIO_W +: PRIO_W]};
          else
            rep_p = {1'b0, ps_q[(idx-PRIV_N)*PRIO_W +: PRIO_W]};
        end
      end

      a_r3_id_eligible: assert property (@(posedge clk) disable iff (rst)
        (id_c != SPURIOUS_ID) |-> elig);

      a_r5_mask_respected: assert property (@(posedge clk) disable iff (rst)
        (id_c != SPURIOUS_ID) |-> (rep_p <= {1'b0, mk_q[gc*PRIO_W +: PRIO_W]}));

      a_r6_irq_below_running: assert property (@(posedge clk) disable iff (rst)
        irq_out[gc] |-> ((id_c != SPURIOUS_ID) && (rep_p < rn_q[gc*RUN_W +: RUN_W])));

      a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!dist_en || !cpu_if_en[gc]) |=>
          (!irq_out[gc] && (pend_id[gc*ID_W +: ID_W] == SPURIOUS_ID)));
    end
  endgenerate
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_CPU (NUM_CPU),
  .SHARED_N(SHARED_N)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dist_en     (dist_en),
  .cpu_if_en   (cpu_if_en),
  .irq_en      (irq_en),
  .irq_pend    (irq_pend),
  .prio_private(prio_private),
  .prio_shared (prio_shared),
  .prio_mask   (prio_mask),
  .run_prio    (run_prio),
  .pend_id     (pend_id),
  .irq_out     (irq_out)
);

// File: tb/test_irq_prio_arbiter.sv
`timescale 1ns/1ps
module test_irq_prio_arbiter;
  localparam int NI = 64;
  localparam int NC = 2;
  localparam int NS = NI - 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dist_en;
  logic [NC-1:0] cpu_if_en;
  logic [NC*NI-1:0] irq_en, irq_pend;
  logic [NC*32*8-1:0] prio_private;
  logic [NS*8-1:0] prio_shared;
  logic [NC*8-1:0] prio_mask;
  logic [NC*9-1:0] run_prio;
  logic [NC*10-1:0] pend_id;
  logic [NC-1:0] irq_out;

  always #5 clk = ~clk;

  irq_prio_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC)) i_irq_prio_arbiter (
    .clk(clk), .rst(rst), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
    .irq_en(irq_en), .irq_pend(irq_pend), .prio_private(prio_private),
    .prio_shared(prio_shared), .prio_mask(prio_mask), .run_prio(run_prio),
    .pend_id(pend_id), .irq_out(irq_out)
  );

  // Behavioural state
  bit m_en [NC][NI];
  bit m_pd [NC][NI];
  int m_pp [NC][32];
  int m_ps [NI];
  int m_mask [NC];
  int m_run [NC];
  bit m_den;
  bit m_cen [NC];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic drive();
    dist_en = m_den;
    for (int c = 0; c < NC; c++) begin
      cpu_if_en[c] = m_cen[c];
      prio_mask[c*8 +: 8] = 8'(m_mask[c]);
      run_prio[c*9 +: 9]  = 9'(m_run[c]);
      for (int i = 0; i < NI; i++) begin
        irq_en[c*NI+i]   = m_en[c][i];
        irq_pend[c*NI+i] = m_pd[c][i];
      end
      for (int i = 0; i < 32; i++) prio_private[(c*32+i)*8 +: 8] = 8'(m_pp[c][i]);
    end
    for (int i = 32; i < NI; i++) prio_shared[(i-32)*8 +: 8] = 8'(m_ps[i]);
  endtask

  task automatic model(input int c, output int eid, output bit eirq);
    int best = 256;
    int bid  = 1023;
    for (int i = 0; i < NI; i++) begin
      if (m_en[c][i] && m_pd[c][i]) begin
        int p = (i < 32) ? m_pp[c][i] : m_ps[i];
        if (p < best) begin best = p; bid = i; end
      end
    end
    if (!m_den || !m_cen[c]) begin
      eid = 1023; eirq = 0;
    end else if (best <= m_mask[c]) begin
      eid = bid; eirq = (best < m_run[c]);
    end else begin
      eid = 1023; eirq = 0;
    end
  endtask

  task automatic cmp(input string tag, input int c, input int eid, input bit eirq);
    int aid = int'(pend_id[c*10 +: 10]);
    n_checks++;
    if (aid != eid || irq_out[c] !== eirq) begin
      n_fail++;
      $display("FAIL %s cpu%0d: id=%0d irq=%b expected id=%0d irq=%b",
               tag, c, aid, irq_out[c], eid, eirq);
    end
  endtask

  task automatic check_now(input string tag);
    for (int c = 0; c < NC; c++) begin
      int eid; bit eirq;
      model(c, eid, eirq);
      cmp(tag, c, eid, eirq);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare.
  task automatic step(input string tag);
    drive();
    @(negedge clk);
    check_now(tag);
  endtask

  task automatic clear_all();
    m_den = 1;
    for (int c = 0; c < NC; c++) begin
      m_cen[c] = 1; m_mask[c] = 8'hF0; m_run[c] = 256;
      for (int i = 0; i < NI; i++) begin m_en[c][i] = 0; m_pd[c][i] = 0; end
      for (int i = 0; i < 32; i++) m_pp[c][i] = 8'hA0;
    end
    for (int i = 0; i < NI; i++) m_ps[i] = 8'hA0;
  endtask

  task automatic set_irq(input int c, input int i, input bit e, input bit p);
    m_en[c][i] = e; m_pd[c][i] = p;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int sid [NC]; bit sirq [NC];
    clear_all();
    for (int c = 0; c < NC; c++) set_irq(c, 40, 1, 1);
    m_ps[40] = 8'h10;
    drive();
    repeat (3) @(negedge clk);
    // R8: outputs idle while reset is held, despite a live candidate
    for (int c = 0; c < NC; c++) cmp("R8 reset", c, 1023, 0);
    rst = 1'b0;

    clear_all();
    step("R3 nothing pending");
    set_irq(0, 40, 0, 1); set_irq(1, 41, 1, 0);
    step("R3 pending without enable");
    m_ps[40] = 8'h80; set_irq(0, 40, 1, 1); set_irq(1, 40, 1, 1);
    step("R1 single shared candidate");
    m_ps[45] = 8'h40; set_irq(0, 45, 1, 1); set_irq(1, 45, 1, 1);
    step("R1 lower value wins");
    m_ps[50] = 8'h40; set_irq(0, 50, 1, 1); set_irq(1, 50, 1, 1);
    step("R2 tie lowest id");
    m_pp[0][3] = 8'h40; set_irq(0, 3, 1, 1);
    step("R2 tie private below shared");

    m_mask[0] = 8'h40;
    step("R5 mask equal passes");
    m_mask[0] = 8'h3F;
    step("R5 mask below blocks");
    m_mask[0] = 8'hF0; m_run[0] = 8'h40;
    step("R6 running equal holds line low");
    m_run[0] = 8'h41;
    step("R6 running above raises line");
    m_run[0] = 256; m_run[1] = 0;
    step("R6 idle vs highest running");
    m_run[1] = 256;

    // R7: same private ID, opposite priorities on the two cores
    m_pp[0][3] = 8'hC0; m_pp[1][3] = 8'h10; set_irq(1, 3, 1, 1);
    step("R7 banked private priority");
    // R9: candidate only in core 1's slice
    clear_all();
    set_irq(1, 60, 1, 1); m_ps[60] = 8'h20;
    step("R9 per-core slices");

    m_den = 0; set_irq(0, 60, 1, 1);
    step("R4 global disable");
    m_den = 1; m_cen[1] = 0;
    step("R4 interface disable");
    m_cen[1] = 1;
    step("R4 re-enable");

    // R8: one-cycle latency; before the next edge the old values remain
    for (int c = 0; c < NC; c++) model(c, sid[c], sirq[c]);
    m_ps[60] = 8'hFF;
    drive();
    #1;
    for (int c = 0; c < NC; c++) cmp("R8 before edge", c, sid[c], sirq[c]);
    @(negedge clk);
    check_now("R8 after edge");

    // R1: pseudo-random sweep with a small priority set to force ties
    for (int n = 0; n < 400; n++) begin
      m_den = ($urandom % 16) != 0;
      for (int c = 0; c < NC; c++) begin
        m_cen[c]  = ($urandom % 16) != 0;
        m_mask[c] = ($urandom % 4) * 8'h40 + ($urandom % 2) * 8'h3F;
        m_run[c]  = ($urandom % 5) * 64;
        for (int i = 0; i < NI; i++) begin
          m_en[c][i] = ($urandom % 3) == 0;
          m_pd[c][i] = ($urandom % 3) == 0;
        end
        for (int i = 0; i < 32; i++) m_pp[c][i] = ($urandom % 4) * 8'h40;
      end
      for (int i = 32; i < NI; i++) m_ps[i] = ($urandom % 4) * 8'h40;
      step("R1 random sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule